// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether one memory access may use a page whose translation entry has already been found. It is given the second word of that entry (protection code bits, no-execute and guarded flags, referenced and changed flags, page class key), the two key bits of the matching segment, the privilege state, the kind of access, and two per-key authority masks, one for data and one for instruction fetches. From these it works out the read, write and execute rights, grants the access or raises a fault, and labels the fault with one bit for each cause.

Three independent rights sources are combined by AND: the no-execute/guard flags, a 3-bit protection code interpreted by the selected segment key, and a 2-bit authority field picked from each mask by the page class key. On a grant the block also asks for the referenced flag and, on stores, the changed flag to be set in memory. It does this through single-cycle strobes only; the write itself belongs to the caller. When the changed flag is still clear, a non-store access is granted without write right, so that a later store comes back through the check and sets the flag.

Top module: `page_perm_eval`

## Requirements
- R1: The segment key used is `seg_key_prob` when `problem_state` is 1 and `seg_key_sup` when it is 0.
- R2: The protection code is {`pte_pp0`, `pte_pp[1:0]`}, with `pte_pp0` as bit 2. With segment key 0, codes 0, 1, 2 allow read, write and execute; codes 3 and 6 allow read and execute; codes 4, 5, 7 allow nothing.
- R3: With segment key 1, code 2 allows read, write and execute; codes 1 and 3 allow read and execute; codes 0, 4, 5, 6, 7 allow nothing.
- R4: `pte_noexec` or `pte_guard` set removes execute right only; read and write are untouched.
- R5: When `dkey_en` is 1, the page key k selects bits [2*(31-k)+1 : 2*(31-k)] of `dkey_mask` (32 keys); the upper bit removes write, the lower removes read. When `dkey_en` is 0 the data mask has no effect.
- R6: When `dkey_en` and `ikey_en` are both 1, bit 2*(31-k) of `ikey_mask` removes execute right only; bit 2*(31-k)+1 has no effect. Otherwise the instruction mask has no effect.
- R7: `acc_type` 00 is a fetch (needs execute), 01 a load (needs read), 10 a store (needs write), 11 is handled as a load; `grant` is 1 exactly when the needed right survives all three sources.
- R8: On a fetch fault, `cause_nxg` is set if the no-execute/guard flags removed execute, else `cause_iprot` if the protection code removed it; independently `cause_ikey` is set if the instruction mask removed it. Data cause bits stay 0.
- R9: On a load or store fault, `cause_dprot` is set if the protection code removed the needed right, `cause_dmask` if the data mask removed it, and `cause_store` for stores. Fetch cause bits stay 0.
- R10: On a grant with `pte_ref` clear, `set_ref` is 1; it is 0 on faults and when `pte_ref` is set.
- R11: On a grant with `pte_chg` clear, a store raises `set_chg`, and any other access reports `perm_w` as 0; on a store `set_chg` is never raised when `pte_chg` is set.
- R12: All outputs are registered: results for an input presented with `in_valid` appear in the next cycle with `out_valid` 1; in a cycle after `in_valid` was 0, and after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry a request this cycle |
| acc_type | input | 2 | 00 fetch, 01 load, 10 store, 11 as load |
| problem_state | input | 1 | 1 for unprivileged access |
| seg_key_prob | input | 1 | Segment key for unprivileged accesses |
| seg_key_sup | input | 1 | Segment key for privileged accesses |
| pte_pp0 | input | 1 | Protection code bit 2 |
| pte_pp | input | 2 | Protection code bits 1:0 |
| pte_noexec | input | 1 | Page no-execute flag |
| pte_guard | input | 1 | Page guarded flag |
| pte_ref | input | 1 | Page referenced flag |
| pte_chg | input | 1 | Page changed flag |
| pte_key | input | 5 | Page class key |
| dkey_en | input | 1 | Enables both authority mask checks |
| ikey_en | input | 1 | Enables the instruction mask check |
| dkey_mask | input | 64 | Data authority mask, 2 bits per key |
| ikey_mask | input | 64 | Instruction authority mask, 2 bits per key |
| out_valid | output | 1 | Result valid |
| grant | output | 1 | Access allowed |
| perm_r | output | 1 | Read right |
| perm_w | output | 1 | Write right (withheld while changed flag clear) |
| perm_x | output | 1 | Execute right |
| cause_nxg | output | 1 | Fetch fault: no-execute/guard |
| cause_iprot | output | 1 | Fetch fault: protection code |
| cause_ikey | output | 1 | Fetch fault: instruction mask |
| cause_dprot | output | 1 | Data fault: protection code |
| cause_store | output | 1 | Data fault on a store |
| cause_dmask | output | 1 | Data fault: data mask |
| set_ref | output | 1 | Request to set the referenced flag |
| set_chg | output | 1 | Request to set the changed flag |

## Verification
Every result, rights, grant, causes and both strobes, is due exactly one clock edge after the request is presented. The bench drives a request on a falling edge, drops `in_valid` on the next falling edge and compares all outputs against its behavioural model at that moment, which lies half a period after the single register stage has loaded. The following falling edge sees an idle cycle, so the return of every output to zero is checked as well.

// File: rtl/perm_pkg.sv
package perm_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_ALT   = 2'b11
    } acc_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } rwx_t;

    typedef struct packed {
        logic grant;
        rwx_t perm;
        logic c_nxg;
        logic c_iprot;
        logic c_ikey;
        logic c_dprot;
        logic c_store;
        logic c_dmask;
        logic s_ref;
        logic s_chg;
    } verdict_t;

    localparam rwx_t RWX_ALL  = '{r: 1'b1, w: 1'b1, x: 1'b1};
    localparam rwx_t RWX_RX   = '{r: 1'b1, w: 1'b0, x: 1'b1};
    localparam rwx_t RWX_NONE = '{r: 1'b0, w: 1'b0, x: 1'b0};

    // Rights granted by the 3-bit protection code under a given segment key.
    function automatic rwx_t code_rights(input logic key, input logic [2:0] code);
        rwx_t res;
        res = RWX_NONE;
        if (!key) begin
            unique case (code)
                3'd0, 3'd1, 3'd2: res = RWX_ALL;
                3'd3, 3'd6:       res = RWX_RX;
                default:          res = RWX_NONE;
            endcase
        end else begin
            unique case (code)
                3'd2:       res = RWX_ALL;
                3'd1, 3'd3: res = RWX_RX;
                default:    res = RWX_NONE;
            endcase
        end
        return res;
    endfunction

    // Right an access kind requires; the spare code behaves as a load.
    function automatic rwx_t needed_right(input acc_e acc);
        rwx_t res;
        unique case (acc)
            ACC_FETCH: res = '{r: 1'b0, w: 1'b0, x: 1'b1};
            ACC_STORE: res = '{r: 1'b0, w: 1'b1, x: 1'b0};
            default:   res = '{r: 1'b1, w: 1'b0, x: 1'b0};
        endcase
        return res;
    endfunction

endpackage

// File: rtl/perm_code_table.sv
module perm_code_table
    import perm_pkg::*;
(
    input  logic       problem_state,
    input  logic       key_prob,
    input  logic       key_sup,
    input  logic       code_hi,
    input  logic [1:0] code_lo,
    output rwx_t       rights
);
    logic       seg_key;
    logic [2:0] code;

    always_comb begin
        seg_key = problem_state ? key_prob : key_sup;
        code    = {code_hi, code_lo};
        rights  = code_rights(seg_key, code);
    end
endmodule

// File: rtl/perm_key_mask.sv
module perm_key_mask
    import perm_pkg::*;
#(
    parameter int  NUM_KEYS = 32,
    parameter int  KEY_W    = $clog2(NUM_KEYS),
    parameter int  MASK_W   = 2 * NUM_KEYS,
    parameter bit  FOR_EXEC = 1'b0
) (
    input  logic [MASK_W-1:0] mask,
    input  logic [KEY_W-1:0]  key,
    input  logic              enable,
    output rwx_t              rights
);
    // Field for key k sits at bit 2*(NUM_KEYS-1-k): key 0 at the top.
    int pos;
    always_comb pos = 2 * (NUM_KEYS - 1 - int'(key));

    generate
        if (FOR_EXEC) begin : g_exec
            always_comb begin
                rights   = RWX_ALL;
                rights.x = ~(enable & mask[pos]);
            end
        end else begin : g_data
            always_comb begin
                rights   = RWX_ALL;
                rights.r = ~(enable & mask[pos]);
                rights.w = ~(enable & mask[pos+1]);
            end
        end
    endgenerate
endmodule

// File: rtl/perm_fault_build.sv
module perm_fault_build
    import perm_pkg::*;
(
    input  acc_e     acc,
    input  rwx_t     nx_rights,
    input  rwx_t     code_rts,
    input  rwx_t     mask_rts,
    input  logic     ref_flag,
    input  logic     chg_flag,
    output verdict_t verdict
);
    rwx_t need;
    rwx_t combined;
    logic allowed;
    logic is_fetch;
    logic is_store;

    always_comb begin
        need     = needed_right(acc);
        combined = nx_rights & code_rts & mask_rts;
        allowed  = ((need & ~combined) == RWX_NONE);
        is_fetch = (acc == ACC_FETCH);
        is_store = (acc == ACC_STORE);

        verdict        = '0;
        verdict.grant  = allowed;
        verdict.perm.r = combined.r;
        verdict.perm.x = combined.x;
        // Write right is held back until the changed flag is recorded.
        verdict.perm.w = combined.w & (chg_flag | is_store);

        if (!allowed) begin
            if (is_fetch) begin
                if (!nx_rights.x)
                    verdict.c_nxg = 1'b1;
                else if (!code_rts.x)
                    verdict.c_iprot = 1'b1;
                verdict.c_ikey = ~mask_rts.x;
            end else begin
                verdict.c_dprot = ((need & ~code_rts) != RWX_NONE);
                verdict.c_dmask = ((need & ~mask_rts) != RWX_NONE);
                verdict.c_store = is_store;
            end
        end else begin
            verdict.s_ref = ~ref_flag;
            verdict.s_chg = ~chg_flag & is_store;
        end
    end
endmodule

// File: rtl/page_perm_eval.sv
module page_perm_eval
    import perm_pkg::*;
#(
    parameter int NUM_KEYS = 32,
    parameter int KEY_W    = $clog2(NUM_KEYS),
    parameter int MASK_W   = 2 * NUM_KEYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        acc_type,
    input  logic              problem_state,
    input  logic              seg_key_prob,
    input  logic              seg_key_sup,
    input  logic              pte_pp0,
    input  logic [1:0]        pte_pp,
    input  logic              pte_noexec,
    input  logic              pte_guard,
    input  logic              pte_ref,
    input  logic              pte_chg,
    input  logic [KEY_W-1:0]  pte_key,
    input  logic              dkey_en,
    input  logic              ikey_en,
    input  logic [MASK_W-1:0] dkey_mask,
    input  logic [MASK_W-1:0] ikey_mask,
    output logic              out_valid,
    output logic              grant,
    output logic              perm_r,
    output logic              perm_w,
    output logic              perm_x,
    output logic              cause_nxg,
    output logic              cause_iprot,
    output logic              cause_ikey,
    output logic              cause_dprot,
    output logic              cause_store,
    output logic              cause_dmask,
    output logic              set_ref,
    output logic              set_chg
);
    acc_e     acc;
    rwx_t     nx_rts;
    rwx_t     code_rts;
    rwx_t     dmask_rts;
    rwx_t     imask_rts;
    rwx_t     mask_rts;
    verdict_t next_v;
    verdict_t held_v;
    logic     held_valid;

    always_comb begin
        acc      = acc_e'(acc_type);
        nx_rts   = RWX_ALL;
        nx_rts.x = ~(pte_noexec | pte_guard);
        mask_rts = dmask_rts & imask_rts;
    end

    perm_code_table u_code (
        .problem_state (problem_state),
        .key_prob      (seg_key_prob),
        .key_sup       (seg_key_sup),
        .code_hi       (pte_pp0),
        .code_lo       (pte_pp),
        .rights        (code_rts)
    );

    perm_key_mask #(
        .NUM_KEYS (NUM_KEYS),
        .KEY_W    (KEY_W),
        .MASK_W   (MASK_W),
        .FOR_EXEC (1'b0)
    ) u_dmask (
        .mask   (dkey_mask),
        .key    (pte_key),
        .enable (dkey_en),
        .rights (dmask_rts)
    );

    perm_key_mask #(
        .NUM_KEYS (NUM_KEYS),
        .KEY_W    (KEY_W),
        .MASK_W   (MASK_W),
        .FOR_EXEC (1'b1)
    ) u_imask (
        .mask   (ikey_mask),
        .key    (pte_key),
        .enable (dkey_en & ikey_en),
        .rights (imask_rts)
    );

    perm_fault_build u_fault (
        .acc       (acc),
        .nx_rights (nx_rts),
        .code_rts  (code_rts),
        .mask_rts  (mask_rts),
        .ref_flag  (pte_ref),
        .chg_flag  (pte_chg),
        .verdict   (next_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_v     <= '0;
        end else begin
            held_valid <= in_valid;
            held_v     <= in_valid ? next_v : '0;
        end
    end

    always_comb begin
        out_valid   = held_valid;
        grant       = held_v.grant;
        perm_r      = held_v.perm.r;
        perm_w      = held_v.perm.w;
        perm_x      = held_v.perm.x;
        cause_nxg   = held_v.c_nxg;
        cause_iprot = held_v.c_iprot;
        cause_ikey  = held_v.c_ikey;
        cause_dprot = held_v.c_dprot;
        cause_store = held_v.c_store;
        cause_dmask = held_v.c_dmask;
        set_ref     = held_v.s_ref;
        set_chg     = held_v.s_chg;
    end
endmodule

// File: rtl/perm_eval_chk.sv
module perm_eval_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [1:0] acc_type,
    input logic       pte_noexec,
    input logic       pte_guard,
    input logic       pte_ref,
    input logic       pte_chg,
    input logic       out_valid,
    input logic       grant,
    input logic       perm_w,
    input logic       perm_x,
    input logic       cause_nxg,
    input logic       cause_iprot,
    input logic       cause_ikey,
    input logic       cause_dprot,
    input logic       cause_store,
    input logic       cause_dmask,
    input logic       set_ref,
    input logic       set_chg
);
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r12_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !grant && !set_ref && !set_chg);
    a_r4_nx_removes_exec: assert property (@(posedge clk) disable iff (rst)
        in_valid && (pte_noexec || pte_guard) |=> !perm_x);
    a_r10_ref_needs_grant: assert property (@(posedge clk) disable iff (rst)
        set_ref |-> out_valid && grant);
    a_r10_ref_only_when_clear: assert property (@(posedge clk) disable iff (rst)
        in_valid && pte_ref |=> !set_ref);
    a_r11_chg_only_store: assert property (@(posedge clk) disable iff (rst)
        in_valid && (acc_type != 2'b10 || pte_chg) |=> !set_chg);
    a_r11_write_withheld: assert property (@(posedge clk) disable iff (rst)
        in_valid && !pte_chg && acc_type != 2'b10 |=> !perm_w);
    a_r8_fetch_causes: assert property (@(posedge clk) disable iff (rst)
        (cause_nxg || cause_iprot || cause_ikey) |-> !grant && !(cause_nxg && cause_iprot));
    a_r8_fetch_causes_on_fetch: assert property (@(posedge clk) disable iff (rst)
        in_valid && acc_type != 2'b00 |=> !cause_nxg && !cause_iprot && !cause_ikey);
    a_r9_data_causes_not_fetch: assert property (@(posedge clk) disable iff (rst)
        in_valid && acc_type == 2'b00 |=> !cause_dprot && !cause_dmask && !cause_store);
    a_r9_data_cause_faults: assert property (@(posedge clk) disable iff (rst)
        (cause_dprot || cause_dmask || cause_store) |-> out_valid && !grant);
endmodule

bind page_perm_eval perm_eval_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .acc_type    (acc_type),
    .pte_noexec  (pte_noexec),
    .pte_guard   (pte_guard),
    .pte_ref     (pte_ref),
    .pte_chg     (pte_chg),
    .out_valid   (out_valid),
    .grant       (grant),
    .perm_w      (perm_w),
    .perm_x      (perm_x),
    .cause_nxg   (cause_nxg),
    .cause_iprot (cause_iprot),
    .cause_ikey  (cause_ikey),
    .cause_dprot (cause_dprot),
    .cause_store (cause_store),
    .cause_dmask (cause_dmask),
    .set_ref     (set_ref),
    .set_chg     (set_chg)
);

// File: tb/sim_page_perm_eval.sv
`timescale 1ns/1ps
module sim_page_perm_eval;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  acc_type = '0;
    logic        problem_state = 1'b0, seg_key_prob = 1'b0, seg_key_sup = 1'b0;
    logic        pte_pp0 = 1'b0;
    logic [1:0]  pte_pp = '0;
    logic        pte_noexec = 1'b0, pte_guard = 1'b0, pte_ref = 1'b1, pte_chg = 1'b1;
    logic [4:0]  pte_key = '0;
    logic        dkey_en = 1'b0, ikey_en = 1'b0;
    logic [63:0] dkey_mask = '0, ikey_mask = '0;
    logic        out_valid, grant, perm_r, perm_w, perm_x;
    logic        cause_nxg, cause_iprot, cause_ikey, cause_dprot, cause_store, cause_dmask;
    logic        set_ref, set_chg;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    page_perm_eval u0 (.*);

    function automatic logic [12:0] observed();
        return {out_valid, grant, perm_r, perm_w, perm_x, cause_nxg, cause_iprot,
                cause_ikey, cause_dprot, cause_store, cause_dmask, set_ref, set_chg};
    endfunction

    // Behavioural model of the requirements; result order matches observed().
    function automatic logic [12:0] model();
        int  key, code, shift;
        bit  cr, cw, cx, dr, dw, ix, ex, fr, fw, fx, ok, fetch, store;
        bit  nxg, iprot, ikey, dprot, dmask;
        key  = problem_state ? int'(seg_key_prob) : int'(seg_key_sup);   // R1
        code = 4 * int'(pte_pp0) + int'(pte_pp);
        cr = 0; cw = 0; cx = 0;
        if (key == 0) begin                                   // R2
            if (code <= 2) begin cr = 1; cw = 1; cx = 1; end
            else if (code == 3 || code == 6) begin cr = 1; cx = 1; end
        end else begin                                        // R3
            if (code == 2) begin cr = 1; cw = 1; cx = 1; end
            else if (code == 1 || code == 3) begin cr = 1; cx = 1; end
        end
        ex = !(pte_noexec || pte_guard);                      // R4
        dr = 1; dw = 1; ix = 1;
        shift = 2 * (31 - int'(pte_key));
        if (dkey_en) begin                                    // R5
            dr = !dkey_mask[shift];
            dw = !dkey_mask[shift + 1];
            if (ikey_en) ix = !ikey_mask[shift];              // R6
        end
        fr = cr && dr; fw = cw && dw; fx = cx && ex && ix;
        fetch = (acc_type == 2'b00);
        store = (acc_type == 2'b10);
        ok = fetch ? fx : (store ? fw : fr);                  // R7
        nxg = 0; iprot = 0; ikey = 0; dprot = 0; dmask = 0;
        if (!ok && fetch) begin                               // R8
            if (!ex) nxg = 1; else if (!cx) iprot = 1;
            ikey = !ix;
        end
        if (!ok && !fetch) begin                              // R9
            dprot = store ? !cw : !cr;
            dmask = store ? !dw : !dr;
        end
        return {1'b1, ok, fr, fw && (pte_chg || store), fx, nxg, iprot, ikey,
                dprot, !ok && !fetch && store, dmask,
                ok && !pte_ref,                               // R10
                ok && !pte_chg && store};                     // R11
    endfunction

    task automatic check(string tag, logic [12:0] act, logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Present one request on a falling edge, check it one edge later,
    // then check the idle cycle that follows.
    task automatic run(string tag, logic [1:0] acc, logic ps, logic kp, logic ks,
                       logic [2:0] code, logic nx, logic gd, logic rf, logic ch,
                       logic [4:0] key, logic de, logic ie,
                       logic [63:0] dm, logic [63:0] im);
        logic [12:0] exp;
        @(negedge clk);
        acc_type = acc; problem_state = ps; seg_key_prob = kp; seg_key_sup = ks;
        pte_pp0 = code[2]; pte_pp = code[1:0]; pte_noexec = nx; pte_guard = gd;
        pte_ref = rf; pte_chg = ch; pte_key = key; dkey_en = de; ikey_en = ie;
        dkey_mask = dm; ikey_mask = im; in_valid = 1'b1;
        exp = model();
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, observed(), exp);
        @(negedge clk);
        check("R12 idle", observed(), 13'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset", observed(), 13'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 after reset", observed(), 13'd0);

        // R1: same code, key picked by privilege.
        run("R1 prob key", 2'b01, 1, 1, 0, 3'd0, 0, 0, 1, 1, 5'd0, 0, 0, '0, '0);
        run("R1 sup key",  2'b01, 0, 1, 0, 3'd0, 0, 0, 1, 1, 5'd0, 0, 0, '0, '0);
        run("R1 sup key1", 2'b10, 0, 0, 1, 3'd1, 0, 0, 1, 1, 5'd0, 0, 0, '0, '0);

        // R2, R3: full code tables for every access kind.
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < 8; c++)
                for (int a = 0; a < 3; a++)
                    run(k == 0 ? "R2 table" : "R3 table", 2'(a), 1'b0, 1'b0, 1'(k),
                        3'(c), 0, 0, 1, 1, 5'd0, 0, 0, '0, '0);

        // R4: no-execute and guard remove execute only.
        run("R4 nx fetch",  2'b00, 0, 0, 0, 3'd0, 1, 0, 1, 1, 5'd0, 0, 0, '0, '0);
        run("R4 nx store",  2'b10, 0, 0, 0, 3'd0, 1, 0, 1, 1, 5'd0, 0, 0, '0, '0);
        run("R4 gd load",   2'b01, 0, 0, 0, 3'd0, 0, 1, 1, 1, 5'd0, 0, 0, '0, '0);
        run("R4 gd fetch",  2'b00, 0, 0, 0, 3'd0, 0, 1, 1, 1, 5'd0, 0, 0, '0, '0);

        // R5: data mask field position and bypass.
        run("R5 key0 wr",   2'b10, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd0, 1, 0, 64'h8000_0000_0000_0000, '0);
        run("R5 key0 rd ok",2'b01, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd0, 1, 0, 64'h8000_0000_0000_0000, '0);
        run("R5 key31 rd",  2'b01, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd31, 1, 0, 64'h1, '0);
        run("R5 key17 wr",  2'b10, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd17, 1, 0, 64'h1 << 29, '0);
        run("R5 bypass",    2'b10, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd0, 0, 0, '1, '0);
        run("R5 other key", 2'b01, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd3, 1, 0, 64'h1, '0);

        // R6: instruction mask.
        run("R6 ikey deny", 2'b00, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd5, 1, 1, '0, 64'h1 << 52);
        run("R6 ikey off",  2'b00, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd5, 1, 0, '0, 64'h1 << 52);
        run("R6 ikey hi",   2'b00, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd5, 1, 1, '0, 64'h1 << 53);
        run("R6 ikey load", 2'b01, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd5, 1, 1, '0, '1);
        run("R6 no denable",2'b00, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd5, 0, 1, '0, '1);

        // R7: spare access code behaves as a load.
        run("R7 alt ok",    2'b11, 0, 0, 0, 3'd3, 0, 0, 1, 1, 5'd0, 0, 0, '0, '0);
        run("R7 alt deny",  2'b11, 0, 0, 1, 3'd0, 0, 0, 1, 1, 5'd0, 0, 0, '0, '0);

        // R8: fetch fault causes.
        run("R8 nx+code",   2'b00, 0, 0, 0, 3'd4, 1, 0, 1, 1, 5'd0, 0, 0, '0, '0);
        run("R8 code only", 2'b00, 0, 0, 0, 3'd5, 0, 0, 1, 1, 5'd0, 0, 0, '0, '0);
        run("R8 code+ikey", 2'b00, 0, 0, 0, 3'd7, 0, 0, 1, 1, 5'd9, 1, 1, '0, 64'h1 << 44);
        run("R8 nx+ikey",   2'b00, 0, 0, 0, 3'd0, 0, 1, 1, 1, 5'd9, 1, 1, '0, 64'h1 << 44);

        // R9: data fault causes.
        run("R9 st code",   2'b10, 0, 0, 0, 3'd3, 0, 0, 1, 1, 5'd0, 0, 0, '0, '0);
        run("R9 ld mask",   2'b01, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd2, 1, 0, 64'h1 << 58, '0);
        run("R9 st both",   2'b10, 0, 0, 0, 3'd6, 0, 0, 1, 1, 5'd2, 1, 0, 64'h2 << 58, '0);

        // R10, R11: flag update requests and write withholding.
        run("R10 ref set",  2'b01, 0, 0, 0, 3'd0, 0, 0, 0, 1, 5'd0, 0, 0, '0, '0);
        run("R10 ref fault",2'b10, 0, 0, 0, 3'd3, 0, 0, 0, 0, 5'd0, 0, 0, '0, '0);
        run("R11 ld no w",  2'b01, 0, 0, 0, 3'd0, 0, 0, 1, 0, 5'd0, 0, 0, '0, '0);
        run("R11 fetch no w",2'b00, 0, 0, 0, 3'd0, 0, 0, 0, 0, 5'd0, 0, 0, '0, '0);
        run("R11 st chg",   2'b10, 0, 0, 0, 3'd0, 0, 0, 0, 0, 5'd0, 0, 0, '0, '0);
        run("R11 st chg set",2'b10, 0, 0, 0, 3'd0, 0, 0, 1, 1, 5'd0, 0, 0, '0, '0);

        // Mixed sweep over all inputs.
        for (int i = 0; i < 400; i++)
            run("R7 sweep", 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                3'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
                1'($urandom), 1'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
                {$urandom, $urandom}, {$urandom, $urandom});

        // R12: synchronous reset clears a held result.
        @(negedge clk);
        acc_type = 2'b01; pte_pp0 = 0; pte_pp = 0; problem_state = 0; seg_key_sup = 0;
        dkey_en = 0; pte_noexec = 0; pte_guard = 0; in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R12 reset clears", observed(), 13'd0);
        rst = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule